// File: doc/BRIEF.md
# Bit-Masked Packed-Pixel Video Memory Port

This block fronts an on-chip byte-organised video memory. The memory is reached through a memory-mapped port that carries 8-, 16- and 32-bit reads and writes at any byte alignment. A write does not simply replace bytes. It merges new data into old data under a 64-bit mask file held as eight bytes, one bit at a time. The upper four mask bytes always repeat the lower four. The mask byte that a data lane uses is chosen from the access's byte offset plus the lane number, so the mask pattern stays tied to screen bytes and not to bus lanes.

The mask file is loaded and read back through a small I/O window with three byte ports. One port holds a 2-bit index. The other two ports are a low and a high mask data port, and the index picks which pair of mask bytes they reach. Every mask write lands in two places, four bytes apart. A memory write is a read-modify-write that takes two cycles, and the port's ready output is low in the second cycle. Reads are not masked and answer in the same cycle.

The memory depth is a parameter, `ADDR_W` bits of byte address. A full-size 512 KiB buffer uses `ADDR_W` = 19. The default is smaller.

Top module: `pxmask_vram`

## Requirements
- R1: Only the low `ADDR_W` bits of `mem_addr` select the memory byte. Higher address bits have no effect on which byte is read or written.
- R2: For each bit of each written lane, the byte becomes (old AND NOT m) OR (new AND m), where m is that lane's mask byte. Set mask bits take the new data and clear mask bits keep the old data.
- R3: Lane i of an access at address A uses mask byte number (A mod 4) + i, in the range 0 to 6.
- R4: `mem_size` 0 accesses one byte, 1 accesses two bytes, and 2 or 3 accesses four bytes. The accesses are little-endian: lane i, at data bits [8i+7:8i], is byte A+i. On a read, lanes beyond the size return zero. On a write, those lanes leave memory unchanged.
- R5: The bytes of a multi-byte access that run past the top of memory wrap to address 0, modulo 2^`ADDR_W`.
- R6: A write to I/O port 0x0458 loads the index from `io_wdata[1:0]`. A read of 0x0458 returns the index in bits [1:0], with all other bits zero.
- R7: A byte write to port 0x045A stores `io_wdata[7:0]` into mask bytes 2*idx and 2*idx+4. A byte write to 0x045B stores it into mask bytes 2*idx+1 and 2*idx+5. Mask byte k and mask byte k+4 stay equal.
- R8: A 16-bit write (`io_wide`=1) to 0x045A stores the low byte as R7 does for 0x045A and the high byte as R7 does for 0x045B.
- R9: A byte read of 0x045A returns mask byte 2*idx, and a byte read of 0x045B returns mask byte 2*idx+1. A 16-bit read of 0x045A returns {byte 2*idx+1, byte 2*idx}. Any other I/O address reads zero.
- R10: After reset, all eight mask bytes are 0xFF and the index is 0.
- R11: When a write is accepted while `mem_ready` is high, `mem_ready` is low in the next cycle and high again in the cycle after that. The written data can be read once `mem_ready` is high again.
- R12: Reads ignore the mask and return the stored bytes unchanged.
- R13: Mask byte positions are computed modulo 8. Index 2 therefore reaches the same bytes as index 0, and index 3 reaches the same bytes as index 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_size | input | 2 | Access size: 0 byte, 1 half, 2 or 3 word |
| mem_addr | input | BUS_AW | Byte address |
| mem_wdata | input | 32 | Write data, little-endian lanes |
| mem_rdata | output | 32 | Read data, valid in the request cycle |
| mem_ready | output | 1 | Low while a write-back is in progress |
| io_req | input | 1 | I/O access request |
| io_we | input | 1 | 1 = I/O write |
| io_wide | input | 1 | 1 = 16-bit I/O access |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, valid in the request cycle |

## Verification
A corrupted mask byte or mirror byte does not show on the memory port until a write uses it. It then appears in the readback of that location, at the latest two cycles after the write is accepted. It can also be seen at once through the I/O readback for the index that reaches it. A wrong lane-to-bank rotation shows at once on the next unaligned read, as bytes that have swapped places. A stuck write-back stage shows as `mem_ready` staying low, or as stale data on the first read after ready returns.

// File: rtl/pxv_pkg.sv
package pxv_pkg;
  localparam int LANES = 4;
  localparam int MASK_BYTES = 8;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  typedef logic [7:0] byte_t;

  // number of lanes an access touches
  function automatic logic [2:0] lane_count(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // lane that lands in a given bank for a given byte offset
  function automatic logic [1:0] bank_lane(input logic [1:0] bank, input logic [1:0] off);
    return bank - off;
  endfunction

  // mask byte slot used by a lane (rotated by offset)
  function automatic logic [2:0] mask_slot(input logic [1:0] off, input logic [1:0] lane);
    return {1'b0, off} + {1'b0, lane};
  endfunction

  // per-bit merge of new data into old data
  function automatic byte_t merge_byte(input byte_t old_b, input byte_t new_b, input byte_t m);
    return (old_b & ~m) | (new_b & m);
  endfunction
endpackage

// File: rtl/pxv_mask_file.sv
module pxv_mask_file
  import pxv_pkg::*;
#(
  parameter logic [15:0] PORT_IDX = 16'h0458,
  parameter logic [15:0] PORT_LO  = 16'h045A,
  parameter logic [15:0] PORT_HI  = 16'h045B
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        io_req,
  input  logic                        io_we,
  input  logic                        io_wide,
  input  logic [15:0]                 io_addr,
  input  logic [15:0]                 io_wdata,
  output logic [15:0]                 io_rdata,
  output logic [MASK_BYTES-1:0][7:0]  mask_o
);
  localparam logic [2:0] MIRROR = 3'(MASK_BYTES / 2);

  logic [1:0]                   idx_q;
  logic [MASK_BYTES-1:0][7:0]   mask_q;
  logic                         hit_idx, hit_lo, hit_hi;
  logic                         idx_wr, lo_wr, hi_wr;
  logic [2:0]                   slot_lo, slot_hi;
  byte_t                        hi_d;

  assign hit_idx = (io_addr == PORT_IDX);
  assign hit_lo  = (io_addr == PORT_LO);
  assign hit_hi  = (io_addr == PORT_HI);
  assign idx_wr  = io_req & io_we & hit_idx;
  assign lo_wr   = io_req & io_we & hit_lo;
  assign hi_wr   = io_req & io_we & (hit_hi | (hit_lo & io_wide));
  assign hi_d    = hit_lo ? io_wdata[15:8] : io_wdata[7:0];
  assign slot_lo = {idx_q, 1'b0};
  assign slot_hi = {idx_q, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      mask_q <= '1;
    end else begin
      if (idx_wr) idx_q <= io_wdata[1:0];
      if (lo_wr) begin
        mask_q[slot_lo]          <= io_wdata[7:0];
        mask_q[slot_lo + MIRROR] <= io_wdata[7:0];
      end
      if (hi_wr) begin
        mask_q[slot_hi]          <= hi_d;
        mask_q[slot_hi + MIRROR] <= hi_d;
      end
    end
  end

  always_comb begin
    io_rdata = '0;
    if (io_req) begin
      if (hit_idx)      io_rdata = {14'd0, idx_q};
      else if (hit_lo)  io_rdata = io_wide ? {mask_q[slot_hi], mask_q[slot_lo]} : {8'd0, mask_q[slot_lo]};
      else if (hit_hi)  io_rdata = {8'd0, mask_q[slot_hi]};
    end
  end

  assign mask_o = mask_q;

  for (genvar k = 0; k < MASK_BYTES / 2; k++) begin : g_mirror_chk
    assert_mirror_equal_R7: assert property (@(posedge clk) disable iff (rst)
      mask_q[k] == mask_q[k + MASK_BYTES / 2]);
  end

  assert_index_load_R6: assert property (@(posedge clk) disable iff (rst)
    idx_wr |=> idx_q == $past(io_wdata[1:0]));

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && idx_q == 2'd0));
endmodule

// File: rtl/pxv_bank.sv
module pxv_bank #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  assert_bank_store_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/pxmask_vram.sv
module pxmask_vram
  import pxv_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BUS_AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [1:0]        mem_size,
  input  logic [BUS_AW-1:0] mem_addr,
  input  logic [31:0]       mem_wdata,
  output logic [31:0]       mem_rdata,
  output logic              mem_ready,
  input  logic              io_req,
  input  logic              io_we,
  input  logic              io_wide,
  input  logic [15:0]       io_addr,
  input  logic [15:0]       io_wdata,
  output logic [15:0]       io_rdata
);
  localparam int WORD_AW = ADDR_W - 2;

  logic [ADDR_W-1:0]           base;
  logic [1:0]                  off;
  logic [2:0]                  nbytes;
  logic                        busy_q;
  logic                        wr_accept;
  logic [MASK_BYTES-1:0][7:0]  mask_w;
  byte_t                       bank_rd [LANES];

  assign base      = mem_addr[ADDR_W-1:0];
  assign off       = base[1:0];
  assign nbytes    = lane_count(mem_size);
  assign wr_accept = mem_req & mem_we & ~busy_q;
  assign mem_ready = ~busy_q;

  pxv_mask_file u_mask (
    .clk      (clk),
    .rst      (rst),
    .io_req   (io_req),
    .io_we    (io_we),
    .io_wide  (io_wide),
    .io_addr  (io_addr),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .mask_o   (mask_w)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic [1:0]         lane;
    logic [ADDR_W-1:0]  byte_addr;
    logic [WORD_AW-1:0] word_addr;
    logic               lane_on;
    byte_t              merged;
    logic               st_we;
    logic [WORD_AW-1:0] st_addr;
    byte_t              st_data;

    assign lane      = bank_lane(2'(k), off);
    assign byte_addr = base + ADDR_W'(lane);
    assign word_addr = byte_addr[ADDR_W-1:2];
    assign lane_on   = ({1'b0, lane} < nbytes);
    assign merged    = merge_byte(bank_rd[k], mem_wdata[8*lane +: 8], mask_w[mask_slot(off, lane)]);

    // first cycle: capture merged byte; second cycle: write it back
    always_ff @(posedge clk) begin
      if (rst) begin
        st_we   <= 1'b0;
        st_addr <= '0;
        st_data <= '0;
      end else begin
        st_we <= wr_accept & lane_on;
        if (wr_accept) begin
          st_addr <= word_addr;
          st_data <= merged;
        end
      end
    end

    pxv_bank #(.AW(WORD_AW)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (st_we),
      .waddr (st_addr),
      .wdata (st_data),
      .raddr (word_addr),
      .rdata (bank_rd[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= wr_accept;
  end

  always_comb begin
    logic [1:0] src;
    mem_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      src = off + 2'(i);
      if (3'(i) < nbytes) mem_rdata[8*i +: 8] = bank_rd[src];
    end
  end

  assert_ready_drop_R11: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> !mem_ready);

  assert_ready_return_R11: assert property (@(posedge clk) disable iff (rst)
    !mem_ready |=> mem_ready);
endmodule

// File: tb/pxmask_vram_test.sv
module pxmask_vram_test;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req = 1'b0, mem_we = 1'b0;
  logic [1:0]  mem_size = 2'd0;
  logic [31:0] mem_addr = '0, mem_wdata = '0;
  logic [31:0] mem_rdata;
  logic        mem_ready;
  logic        io_req = 1'b0, io_we = 1'b0, io_wide = 1'b0;
  logic [15:0] io_addr = '0, io_wdata = '0;
  logic [15:0] io_rdata;

  int checks = 0;
  int errors = 0;
  logic        exp_ready = 1'b1;
  logic [7:0]  ref_mem [DEPTH];
  logic [7:0]  ref_mask [8];
  int          ref_idx = 0;

  pxmask_vram #(.ADDR_W(ADDR_W), .BUS_AW(32)) uut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .io_req(io_req), .io_we(io_we), .io_wide(io_wide), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nlanes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a, input logic [1:0] sz);
    logic [31:0] r = '0;
    for (int i = 0; i < nlanes(sz); i++) r[8*i +: 8] = ref_mem[(int'(a) + i) & (DEPTH - 1)];
    return r;
  endfunction

  function automatic void model_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    for (int i = 0; i < nlanes(sz); i++) begin
      int p = (int'(a) + i) & (DEPTH - 1);
      logic [7:0] m = ref_mask[int'(a & 3) + i];
      ref_mem[p] = (ref_mem[p] & ~m) | (d[8*i +: 8] & m);
    end
  endfunction

  // per-clock comparison of the ready output against the model
  always @(negedge clk) if (!rst) chk("R11 ready", {31'd0, mem_ready}, {31'd0, exp_ready});

  task automatic mem_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b1; mem_addr = a; mem_size = sz; mem_wdata = d;
    @(posedge clk); #1 exp_ready = 1'b0; model_write(a, sz, d);
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0;
    @(posedge clk); #1 exp_ready = 1'b1;
  endtask

  task automatic mem_read(input string tag, input logic [31:0] a, input logic [1:0] sz);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = a; mem_size = sz;
    #1 chk(tag, mem_rdata, model_read(a, sz));
    mem_req = 1'b0;
  endtask

  task automatic mem_read_lit(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] exp);
    @(negedge clk);
    mem_req = 1'b1; mem_we = 1'b0; mem_addr = a; mem_size = sz;
    #1 chk(tag, mem_rdata, exp);
    mem_req = 1'b0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic wide, input logic [15:0] d);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b1; io_wide = wide; io_addr = a; io_wdata = d;
    @(posedge clk); #1;
    if (a == 16'h0458) ref_idx = int'(d[1:0]);
    else if (a == 16'h045A) begin
      ref_mask[(2*ref_idx) % 8] = d[7:0];
      ref_mask[(2*ref_idx + 4) % 8] = d[7:0];
      if (wide) begin
        ref_mask[(2*ref_idx + 1) % 8] = d[15:8];
        ref_mask[(2*ref_idx + 5) % 8] = d[15:8];
      end
    end else if (a == 16'h045B) begin
      ref_mask[(2*ref_idx + 1) % 8] = d[7:0];
      ref_mask[(2*ref_idx + 5) % 8] = d[7:0];
    end
    @(negedge clk);
    io_req = 1'b0; io_we = 1'b0; io_wide = 1'b0;
  endtask

  task automatic io_read(input string tag, input logic [15:0] a, input logic wide, input logic [15:0] exp);
    @(negedge clk);
    io_req = 1'b1; io_we = 1'b0; io_wide = wide; io_addr = a;
    #1 chk(tag, {16'd0, io_rdata}, {16'd0, exp});
    io_req = 1'b0; io_wide = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ref_mask[i] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R10: reset state seen through the I/O window
    io_read("R10 index", 16'h0458, 1'b0, 16'h0000);
    io_read("R10 mask pair idx0", 16'h045A, 1'b1, 16'hFFFF);
    io_write(16'h0458, 1'b0, 16'h0001);
    io_read("R10 mask pair idx1", 16'h045A, 1'b1, 16'hFFFF);
    io_write(16'h0458, 1'b0, 16'h0000);

    // fill memory with full-mask word writes (R10 all bits writable)
    for (int w = 0; w < DEPTH / 4; w++)
      mem_write(32'(w * 4), 2'd2, 32'(w) * 32'h9E3779B1 ^ 32'h5A5A5A5A);
    for (int w = 0; w < DEPTH / 4; w += 37) mem_read("R10 R4 fill readback", 32'(w * 4), 2'd2);

    // R1: high address bits ignored
    mem_write(32'h8000_0010, 2'd0, 32'h0000_00C7);
    mem_read_lit("R1 low alias", 32'h0000_0010, 2'd0, 32'h0000_00C7);
    mem_read("R1 high alias", 32'hFFFF_FC10, 2'd2);

    // R4: sizes and little-endian lanes
    mem_write(32'h21, 2'd1, 32'hDEAD_BEEF);
    mem_read_lit("R4 half lane0", 32'h21, 2'd0, 32'h0000_00EF);
    mem_read_lit("R4 half lane1", 32'h22, 2'd0, 32'h0000_00BE);
    mem_read("R4 word spans half", 32'h20, 2'd2);
    mem_read("R4 size3 as word", 32'h23, 2'd3);

    // R6, R7, R8, R9: program the mask file
    io_write(16'h0458, 1'b0, 16'h00FC);
    io_read("R6 index low bits only", 16'h0458, 1'b0, 16'h0000);
    io_write(16'h045A, 1'b0, 16'h000F);
    io_write(16'h045B, 1'b0, 16'h00F0);
    io_read("R9 byte lo", 16'h045A, 1'b0, 16'h000F);
    io_read("R9 byte hi", 16'h045B, 1'b0, 16'h00F0);
    io_write(16'h0458, 1'b0, 16'h0001);
    io_read("R6 index readback", 16'h0458, 1'b1, 16'h0001);
    io_write(16'h045A, 1'b1, 16'h3CC3);
    io_read("R8 wide write readback", 16'h045A, 1'b1, 16'h3CC3);
    io_read("R9 unmapped port", 16'h0459, 1'b0, 16'h0000);

    // R2, R3 with literal values on zeroed memory
    io_write(16'h0458, 1'b0, 16'h0000);
    io_write(16'h045A, 1'b1, 16'hFFFF);
    io_write(16'h0458, 1'b0, 16'h0001);
    io_write(16'h045A, 1'b1, 16'hFFFF);
    mem_write(32'h80, 2'd2, 32'h0);
    mem_write(32'h84, 2'd2, 32'h0);
    mem_write(32'h88, 2'd2, 32'h0);
    io_write(16'h045A, 1'b1, 16'h3CC3);
    io_write(16'h0458, 1'b0, 16'h0000);
    io_write(16'h045A, 1'b1, 16'hF00F);
    mem_write(32'h80, 2'd2, 32'hFFFF_FFFF);
    mem_read_lit("R2 aligned merge", 32'h80, 2'd2, 32'h3CC3_F00F);
    mem_write(32'h85, 2'd2, 32'hFFFF_FFFF);
    mem_read_lit("R3 offset1 lanes", 32'h84, 2'd2, 32'h3CC3_F000);
    mem_read_lit("R3 offset1 mirror lane", 32'h88, 2'd0, 32'h0000_000F);
    mem_read_lit("R7 mirror check via lane", 32'h89, 2'd0, 32'h0000_0000);
    for (int o = 0; o < 4; o++) begin
      mem_write(32'h100 + 32'(o), 2'd2, 32'h0000_0000);
      mem_read("R3 rotated clear", 32'h100 + 32'(o), 2'd2);
      mem_write(32'h140 + 32'(o), 2'd1, 32'h0000_A5A5);
      mem_read("R2 half merge", 32'h140 + 32'(o), 2'd2);
    end
    mem_write(32'h1C3, 2'd0, 32'hFFFF_FFFF);
    mem_read("R4 byte write leaves neighbours", 32'h1C0, 2'd2);
    mem_read("R12 unmasked read", 32'h84, 2'd2);

    // R5: wrap past the top of memory
    mem_write(32'(DEPTH - 2), 2'd2, 32'h1234_5678);
    mem_read("R5 wrap word", 32'(DEPTH - 2), 2'd2);
    mem_read("R5 wrap low bytes", 32'h0, 2'd1);
    mem_read("R5 wrap read offset3", 32'(DEPTH - 1), 2'd2);

    // R13: index 2 and 3 alias 0 and 1
    io_write(16'h0458, 1'b0, 16'h0002);
    io_read("R6 index 2", 16'h0458, 1'b0, 16'h0002);
    io_write(16'h045A, 1'b0, 16'h0011);
    io_read("R13 idx2 lo", 16'h045A, 1'b0, 16'h0011);
    io_write(16'h0458, 1'b0, 16'h0000);
    io_read("R13 idx0 sees idx2 write", 16'h045A, 1'b0, 16'h0011);
    io_write(16'h0458, 1'b0, 16'h0003);
    io_read("R13 idx3 hi", 16'h045B, 1'b0, 16'h003C);
    mem_write(32'h200, 2'd2, 32'hFFFF_FFFF);
    mem_read("R13 R2 merge after alias", 32'h200, 2'd2);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule